// File: doc/BRIEF.md
# Round-Trip Delay Meter with Receive-Path Autocalibration

This block times a link's round trip and then trims it. A local frame generator emits a one-cycle transmit frame-start pulse once per radio frame. It also emits one when an external sync request arrives. The block counts link clock cycles from that pulse to the next receive frame-start marker that leaves the block's own receive pipeline. It reports the count as the measured round-trip delay.

The receive word stream and its frame-start marker pass through a pipeline of selectable depth. This pipeline sits directly after the receive elastic buffer. When calibration is enabled, each accepted measurement is compared with a target value written by software, and the depth moves by one stage toward that target. Depth changes only on a transmit frame boundary. The measurement that follows a change is discarded while the pipeline settles. Status outputs show when the loop has locked onto the target and when the target lies outside the reachable depth range. A timeout flag marks frames in which no receive marker came back.

Top module: `rtd_autocal`

## Requirements
- R1: `tx_fs` pulses for one cycle every FRAME_LEN cycles. The first pulse comes on the FRAME_LEN-th rising edge after reset is released.
- R2: `sync_req` high at a rising edge makes `tx_fs` pulse in the following cycle. The frame counter restarts from that pulse, so the next free-running pulse comes FRAME_LEN cycles later.
- R3: When `rx_fs_out` is high d cycles after a `tx_fs` pulse (0 <= d <= FRAME_LEN-1), `rtd_valid` pulses one cycle later and `rtd_value` becomes d. A `rx_fs_out` with no open measurement is ignored.
- R4: If no `rx_fs_out` arrives within FRAME_LEN-1 cycles after `tx_fs`, `rtd_timeout` goes high and `rtd_value` keeps its last valid value. The flag clears with the next valid measurement.
- R5: `rx_data_out` and `rx_fs_out` equal `rx_data_in` and `rx_fs_in` delayed by exactly `cal_depth` cycles. Depth 0 is a direct combinational path.
- R6: When the pipeline is built without the calibration feature (PIPE_EN = 0), `cal_depth` is always 0 and the receive path adds no latency.
- R7: With `cal_en` = 1, an accepted measurement below `cal_target` requests one more stage, and one above requests one fewer. Depth stays within 0 to MAX_DEPTH (default 5).
- R8: `cal_depth` changes only in the cycle after a `tx_fs` pulse, and only by one. The first measurement after a change is discarded, so changes are at least two frames apart.
- R9: With `cal_en` = 0, `cal_depth` holds its value, and `cal_locked` and `cal_unreach` are 0.
- R10: `cal_locked` is set by an accepted measurement equal to the target. `cal_unreach` is set by an accepted measurement that is below the target at maximum depth, or above it at depth 0. A mismatch clears `cal_locked`. The two flags are never high together.
- R11: During reset, `tx_fs`, `rtd_valid`, `rtd_timeout`, `rtd_value`, `cal_depth`, `cal_locked` and `cal_unreach` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req | input | 1 | External request to start a transmit frame now |
| tx_fs | output | 1 | Transmit frame-start pulse |
| rx_fs_in | input | 1 | Receive frame-start marker from the elastic buffer |
| rx_data_in | input | DATA_W | Receive word from the elastic buffer |
| rx_fs_out | output | 1 | Frame-start marker after the calibration pipeline |
| rx_data_out | output | DATA_W | Receive word after the calibration pipeline |
| cal_en | input | 1 | Calibration enable |
| cal_target | input | CNT_W | Desired round-trip delay in link cycles |
| rtd_value | output | CNT_W | Last measured round-trip delay |
| rtd_valid | output | 1 | One-cycle strobe for a new measurement |
| rtd_timeout | output | 1 | No receive marker came back in the last frame |
| cal_depth | output | DEPTH_W | Current pipeline depth |
| cal_locked | output | 1 | Last accepted measurement equals the target |
| cal_unreach | output | 1 | Target lies outside the reachable depth range |

## Verification
Some properties are checked on every cycle:
- the depth stays in range, changes only after a frame pulse, and moves by one stage;
- the depth holds while calibration is disabled;
- a sync request is always followed by a frame pulse;
- a valid measurement stays below one frame and clears the timeout;
- the lock and unreachable flags are never high together.

Other behaviour needs bench scenarios with a modelled cable delay:
- convergence of the depth toward the target from several cable-delay and target pairs;
- the pipeline's data alignment, checked at each depth;
- the first-pulse timing and the frame period;
- the two-frame spacing between depth steps;
- the timeout and its recovery when the receive marker stops.

// File: rtl/rtd_pkg.sv
// Shared types for the round-trip delay meter and autocalibration loop.
package rtd_pkg;

    // Outcome of comparing one measurement with the calibration target.
    typedef enum logic [1:0] {
        CMP_BELOW = 2'd0,
        CMP_EQUAL = 2'd1,
        CMP_ABOVE = 2'd2
    } rtd_cmp_e;

endpackage

// File: rtl/rtd_txframe.sv
// Transmit frame-start generator.
// Emits a one-cycle pulse every FRAME_LEN cycles from a free-running frame
// counter, or in the cycle after sync_req, which also restarts the counter.
// Assumes FRAME_LEN >= 2.
module rtd_txframe #(
    parameter int FRAME_LEN = 3072000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    output logic tx_fs
);
    localparam int FR_W = $clog2(FRAME_LEN);
    localparam logic [FR_W-1:0] LAST = FR_W'(FRAME_LEN - 1);

    logic [FR_W-1:0] pos_q;

    // Advance the frame position and raise the pulse at wrap or on sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            tx_fs <= 1'b0;
        end else if (sync_req || pos_q == LAST) begin
            pos_q <= '0;
            tx_fs <= 1'b1;
        end else begin
            pos_q <= pos_q + 1'b1;
            tx_fs <= 1'b0;
        end
    end
endmodule

// File: rtl/rtd_meter.sv
// Round-trip delay meter.
// Opens a measurement on each transmit frame pulse and closes it on the first
// receive frame marker that follows. The result is the cycle distance between
// the two. When no marker returns within FRAME_LEN-1 cycles, the measurement is
// abandoned, the timeout flag is raised and the last result is kept.
// Assumes FRAME_LEN - 1 fits in CNT_W bits.
module rtd_meter #(
    parameter int CNT_W     = 22,
    parameter int FRAME_LEN = 3072000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_fs,
    input  logic             rx_fs,
    output logic [CNT_W-1:0] value,
    output logic             valid,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] run_q;
    logic             open_q;

    // Run the open measurement and record its result or its timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            open_q  <= 1'b0;
            value   <= '0;
            valid   <= 1'b0;
            timeout <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tx_fs) begin
                if (rx_fs) begin
                    value   <= '0;
                    valid   <= 1'b1;
                    timeout <= 1'b0;
                    open_q  <= 1'b0;
                end else begin
                    open_q <= 1'b1;
                    run_q  <= CNT_W'(1);
                end
            end else if (open_q) begin
                if (rx_fs) begin
                    value   <= run_q;
                    valid   <= 1'b1;
                    timeout <= 1'b0;
                    open_q  <= 1'b0;
                end else if (run_q >= LAST) begin
                    timeout <= 1'b1;
                    open_q  <= 1'b0;
                end else if (run_q != CNT_TOP) begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtd_pipe.sv
// Selectable-depth receive pipeline placed after the elastic buffer.
// All stages shift every cycle, and the output taps the stage chosen by depth.
// Depth 0 is a direct path. With PIPE_EN = 0 no stages are built.
// Assumes depth <= MAX_DEPTH.
module rtd_pipe #(
    parameter int DATA_W    = 32,
    parameter int MAX_DEPTH = 5,
    parameter int PIPE_EN   = 1,
    parameter int DEPTH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH_W-1:0] depth,
    input  logic              in_fs,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_fs,
    output logic [DATA_W-1:0] out_data
);
    generate
        if (PIPE_EN != 0) begin : g_pipe
            logic [DATA_W-1:0] stg_d [1:MAX_DEPTH];
            logic              stg_f [1:MAX_DEPTH];

            // Shift the word and its marker one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 1; k <= MAX_DEPTH; k++) begin
                        stg_d[k] <= '0;
                        stg_f[k] <= 1'b0;
                    end
                end else begin
                    stg_d[1] <= in_data;
                    stg_f[1] <= in_fs;
                    for (int k = 2; k <= MAX_DEPTH; k++) begin
                        stg_d[k] <= stg_d[k-1];
                        stg_f[k] <= stg_f[k-1];
                    end
                end
            end

            // Tap the output at the selected stage.
            always_comb begin
                out_data = in_data;
                out_fs   = in_fs;
                for (int k = 1; k <= MAX_DEPTH; k++) begin
                    if (depth == DEPTH_W'(k)) begin
                        out_data = stg_d[k];
                        out_fs   = stg_f[k];
                    end
                end
            end
        end else begin : g_bypass
            logic unused_pipe;
            assign unused_pipe = ^{depth, clk, rst_n};
            assign out_data    = in_data;
            assign out_fs      = in_fs;
        end
    endgenerate
endmodule

// File: rtl/rtd_ctrl.sv
// Autocalibration controller.
// Compares each accepted measurement with the target and requests a step of
// one stage toward it, limited to 0..MAX_DEPTH. The request is applied on the
// next transmit frame pulse, and the measurement that follows is discarded.
// Also keeps the lock and unreachable flags.
// Assumes at most one measurement per frame.
module rtd_ctrl
    import rtd_pkg::*;
#(
    parameter int CNT_W     = 22,
    parameter int MAX_DEPTH = 5,
    parameter int PIPE_EN   = 1,
    parameter int DEPTH_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_fs,
    input  logic               cal_en,
    input  logic [CNT_W-1:0]   target,
    input  logic               meas_valid,
    input  logic [CNT_W-1:0]   meas_value,
    output logic [DEPTH_W-1:0] depth,
    output logic               locked,
    output logic               unreach
);
    localparam logic [DEPTH_W-1:0] TOP = DEPTH_W'(MAX_DEPTH);
    localparam bit                 HAS_PIPE = (PIPE_EN != 0);

    rtd_cmp_e           cmp;
    logic               active;
    logic [DEPTH_W-1:0] pend_q;
    logic               pend_v_q;
    logic               skip_q;

    // Classify the measurement against the target.
    always_comb begin
        if (meas_value < target)      cmp = CMP_BELOW;
        else if (meas_value > target) cmp = CMP_ABOVE;
        else                          cmp = CMP_EQUAL;
    end

    assign active = cal_en && HAS_PIPE;

    // Decide the next depth, apply it on a frame boundary, keep the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            skip_q   <= 1'b0;
            locked   <= 1'b0;
            unreach  <= 1'b0;
        end else if (!active) begin
            pend_v_q <= 1'b0;
            skip_q   <= 1'b0;
            locked   <= 1'b0;
            unreach  <= 1'b0;
        end else begin
            if (meas_valid) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    unique case (cmp)
                        CMP_BELOW: begin
                            locked <= 1'b0;
                            if (depth == TOP) begin
                                unreach <= 1'b1;
                            end else begin
                                unreach  <= 1'b0;
                                pend_q   <= depth + 1'b1;
                                pend_v_q <= 1'b1;
                            end
                        end
                        CMP_ABOVE: begin
                            locked <= 1'b0;
                            if (depth == '0) begin
                                unreach <= 1'b1;
                            end else begin
                                unreach  <= 1'b0;
                                pend_q   <= depth - 1'b1;
                                pend_v_q <= 1'b1;
                            end
                        end
                        default: begin
                            locked  <= 1'b1;
                            unreach <= 1'b0;
                        end
                    endcase
                end
            end
            if (tx_fs && pend_v_q) begin
                depth    <= pend_q;
                pend_v_q <= 1'b0;
                skip_q   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtd_autocal.sv
// Top level: round-trip delay meter with receive-path autocalibration.
// Connects the frame generator, the selectable pipeline, the meter, which
// watches the pipeline output, and the calibration controller that sets the
// depth.
// Assumes the cable delay plus MAX_DEPTH is below FRAME_LEN.
module rtd_autocal #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 22,
    parameter int FRAME_LEN = 3072000,
    parameter int MAX_DEPTH = 5,
    parameter int PIPE_EN   = 1,
    parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_req,
    output logic               tx_fs,
    input  logic               rx_fs_in,
    input  logic [DATA_W-1:0]  rx_data_in,
    output logic               rx_fs_out,
    output logic [DATA_W-1:0]  rx_data_out,
    input  logic               cal_en,
    input  logic [CNT_W-1:0]   cal_target,
    output logic [CNT_W-1:0]   rtd_value,
    output logic               rtd_valid,
    output logic               rtd_timeout,
    output logic [DEPTH_W-1:0] cal_depth,
    output logic               cal_locked,
    output logic               cal_unreach
);
    rtd_txframe #(.FRAME_LEN(FRAME_LEN)) u_txf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .tx_fs    (tx_fs)
    );

    rtd_pipe #(
        .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH),
        .PIPE_EN(PIPE_EN), .DEPTH_W(DEPTH_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .depth    (cal_depth),
        .in_fs    (rx_fs_in),
        .in_data  (rx_data_in),
        .out_fs   (rx_fs_out),
        .out_data (rx_data_out)
    );

    rtd_meter #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_fs   (tx_fs),
        .rx_fs   (rx_fs_out),
        .value   (rtd_value),
        .valid   (rtd_valid),
        .timeout (rtd_timeout)
    );

    rtd_ctrl #(
        .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH),
        .PIPE_EN(PIPE_EN), .DEPTH_W(DEPTH_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_fs      (tx_fs),
        .cal_en     (cal_en),
        .target     (cal_target),
        .meas_valid (rtd_valid),
        .meas_value (rtd_value),
        .depth      (cal_depth),
        .locked     (cal_locked),
        .unreach    (cal_unreach)
    );
endmodule

// File: rtl/rtd_autocal_chk.sv
// Property checker for rtd_autocal, attached with bind.
// Watches only the top-level ports and raises nothing on its own.
module rtd_autocal_chk #(
    parameter int CNT_W     = 22,
    parameter int FRAME_LEN = 3072000,
    parameter int MAX_DEPTH = 5,
    parameter int PIPE_EN   = 1,
    parameter int DEPTH_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_req,
    input logic               tx_fs,
    input logic               cal_en,
    input logic [CNT_W-1:0]   rtd_value,
    input logic               rtd_valid,
    input logic               rtd_timeout,
    input logic [DEPTH_W-1:0] cal_depth,
    input logic               cal_locked,
    input logic               cal_unreach
);
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [DEPTH_W-1:0] TOP   = DEPTH_W'(MAX_DEPTH);
    localparam logic [DEPTH_W-1:0] ONE_D = DEPTH_W'(1);
    localparam bit                 NO_PIPE = (PIPE_EN == 0);

    a_r2_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> tx_fs);

    a_r3_value_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rtd_valid |-> rtd_value <= LAST);

    a_r4_valid_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rtd_valid |-> !rtd_timeout);

    a_r6_no_pipe_depth0: assert property (@(posedge clk) disable iff (!rst_n)
        NO_PIPE |-> cal_depth == '0);

    a_r7_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
        cal_depth <= TOP);

    a_r8_step_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_depth != $past(cal_depth)) |->
            ($past(tx_fs) && (cal_depth == $past(cal_depth) + ONE_D ||
                              $past(cal_depth) == cal_depth + ONE_D)));

    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> $stable(cal_depth));

    a_r9_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> (!cal_locked && !cal_unreach));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_locked && cal_unreach));
endmodule

bind rtd_autocal rtd_autocal_chk #(
    .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN), .MAX_DEPTH(MAX_DEPTH),
    .PIPE_EN(PIPE_EN), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_req    (sync_req),
    .tx_fs       (tx_fs),
    .cal_en      (cal_en),
    .rtd_value   (rtd_value),
    .rtd_valid   (rtd_valid),
    .rtd_timeout (rtd_timeout),
    .cal_depth   (cal_depth),
    .cal_locked  (cal_locked),
    .cal_unreach (cal_unreach)
);

// File: tb/sim_rtd_autocal.sv
// Bench for rtd_autocal: a modelled cable delay feeds the transmit pulse back
// as the receive marker, and the checks use expected values from bench functions.
module sim_rtd_autocal;
    localparam int LEN  = 40;
    localparam int CW   = 12;
    localparam int DW   = 16;
    localparam int MAXD = 5;
    localparam int DPW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_req = 1'b0;
    logic rx_fs_in = 1'b0;
    logic [DW-1:0] rx_data_in = '0;
    logic cal_en = 1'b0;
    logic [CW-1:0] cal_target = '0;

    logic tx_fs, rx_fs_out, rtd_valid, rtd_timeout, cal_locked, cal_unreach;
    logic [DW-1:0] rx_data_out;
    logic [CW-1:0] rtd_value;
    logic [DPW-1:0] cal_depth;

    logic tx_fs1, rx_fs_out1, rtd_valid1, rtd_timeout1, cal_locked1, cal_unreach1;
    logic [DW-1:0] rx_data_out1;
    logic [CW-1:0] rtd_value1;
    logic [DPW-1:0] cal_depth1;

    always #5 clk = ~clk;

    rtd_autocal #(.DATA_W(DW), .CNT_W(CW), .FRAME_LEN(LEN), .MAX_DEPTH(MAXD),
                  .PIPE_EN(1), .DEPTH_W(DPW)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .tx_fs(tx_fs),
        .rx_fs_in(rx_fs_in), .rx_data_in(rx_data_in), .rx_fs_out(rx_fs_out),
        .rx_data_out(rx_data_out), .cal_en(cal_en), .cal_target(cal_target),
        .rtd_value(rtd_value), .rtd_valid(rtd_valid), .rtd_timeout(rtd_timeout),
        .cal_depth(cal_depth), .cal_locked(cal_locked), .cal_unreach(cal_unreach));

    rtd_autocal #(.DATA_W(DW), .CNT_W(CW), .FRAME_LEN(LEN), .MAX_DEPTH(MAXD),
                  .PIPE_EN(0), .DEPTH_W(DPW)) u1 (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .tx_fs(tx_fs1),
        .rx_fs_in(rx_fs_in), .rx_data_in(rx_data_in), .rx_fs_out(rx_fs_out1),
        .rx_data_out(rx_data_out1), .cal_en(cal_en), .cal_target(cal_target),
        .rtd_value(rtd_value1), .rtd_valid(rtd_valid1), .rtd_timeout(rtd_timeout1),
        .cal_depth(cal_depth1), .cal_locked(cal_locked1), .cal_unreach(cal_unreach1));

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int cable = 4;
    bit no_rx = 1'b0;
    bit done = 1'b0;
    logic thist [64];
    logic [DW-1:0] dhist [8];
    int last_tx = -1;
    int last_chg = -1;
    int prev_depth = 0;
    int valid_cnt = 0;

    function automatic int exp_depth(int l, int t);
        int d = t - l;
        if (d < 0) d = 0;
        if (d > MAXD) d = MAXD;
        return d;
    endfunction

    function automatic bit exp_lock(int l, int t);
        return (t - l >= 0) && (t - l <= MAXD);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // One cycle: drive inputs at the falling edge, then run the per-cycle checks.
    task automatic tick();
        bit sync_was;
        @(negedge clk);
        sync_was = sync_req;
        for (int i = 63; i > 0; i--) thist[i] = thist[i-1];
        thist[0] = tx_fs;
        for (int i = 7; i > 0; i--) dhist[i] = dhist[i-1];
        dhist[0] = rst_n ? DW'($urandom) : '0;
        rx_data_in = dhist[0];
        rx_fs_in = no_rx ? 1'b0 : thist[cable];
        #1;
        cyc++;
        if (rtd_valid) valid_cnt++;
        if (rst_n) begin
            chk(rx_data_out == dhist[cal_depth], "R5", "pipeline data",
                int'(rx_data_out), int'(dhist[cal_depth]));
            chk(rx_data_out1 == rx_data_in && cal_depth1 == 0, "R6", "no-pipe passthrough",
                int'(rx_data_out1), int'(rx_data_in));
            if (sync_was) chk(tx_fs == 1'b1, "R2", "pulse after sync", int'(tx_fs), 1);
            if (tx_fs) begin
                if (last_tx >= 0 && !sync_was)
                    chk(cyc - last_tx == LEN, "R1", "frame period", cyc - last_tx, LEN);
                last_tx = cyc;
            end
            if (int'(cal_depth) != prev_depth) begin
                chk(thist[1] == 1'b1, "R8", "change after frame pulse", int'(thist[1]), 1);
                chk(int'(cal_depth) - prev_depth == 1 || prev_depth - int'(cal_depth) == 1,
                    "R8", "single step", int'(cal_depth), prev_depth);
                if (last_chg >= 0)
                    chk(cyc - last_chg >= 2 * LEN, "R8", "settle gap", cyc - last_chg, 2 * LEN);
                last_chg = cyc;
                prev_depth = int'(cal_depth);
            end
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Program a cable delay and target, let the loop settle, check steady state.
    task automatic trial(int l, int t);
        int ed;
        cable = l;
        cal_target = CW'(t);
        run(16 * LEN);
        ed = exp_depth(l, t);
        chk(int'(cal_depth) == ed, "R7", "converged depth", int'(cal_depth), ed);
        chk(int'(rtd_value) == l + ed, "R3", "measured delay", int'(rtd_value), l + ed);
        chk(cal_locked == exp_lock(l, t), "R10", "locked flag", int'(cal_locked), int'(exp_lock(l, t)));
        chk(cal_unreach == !exp_lock(l, t), "R10", "unreachable flag", int'(cal_unreach), int'(!exp_lock(l, t)));
        valid_cnt = 0;
        run(2 * LEN);
        chk(valid_cnt == 2, "R3", "one result per frame", valid_cnt, 2);
        chk(rtd_timeout == 1'b0, "R4", "no timeout while linked", int'(rtd_timeout), 0);
    endtask

    initial begin
        int n;
        int held_val;
        int held_depth;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) thist[i] = 1'b0;
        for (int i = 0; i < 8; i++) dhist[i] = '0;

        run(3);
        chk(tx_fs == 0 && rtd_valid == 0 && rtd_timeout == 0, "R11", "reset pulses",
            int'({tx_fs, rtd_valid, rtd_timeout}), 0);
        chk(rtd_value == 0 && cal_depth == 0, "R11", "reset value/depth",
            int'(rtd_value) + int'(cal_depth), 0);
        chk(cal_locked == 0 && cal_unreach == 0, "R11", "reset flags",
            int'({cal_locked, cal_unreach}), 0);

        rst_n = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
        end while (!tx_fs && n < 200);
        chk(n == LEN, "R1", "first pulse", n, LEN);

        // R2: a sync in mid-frame restarts the frame.
        run(13);
        sync_req = 1'b1;
        tick();
        sync_req = 1'b0;
        n = 0;
        do begin
            tick();
            n++;
        end while (!tx_fs && n < 200);
        chk(n == LEN, "R2", "restart period", n, LEN);

        // R3 measurement with calibration off, depth 0.
        cable = 7;
        run(3 * LEN);
        chk(int'(rtd_value) == 7, "R3", "raw delay depth 0", int'(rtd_value), 7);

        // Directed calibration corners.
        cal_en = 1'b1;
        trial(4, 6);
        trial(4, 2);
        trial(3, 11);
        trial(5, 10);
        trial(5, 5);

        // R4: remove the receive marker, then restore it.
        held_val = int'(rtd_value);
        held_depth = int'(cal_depth);
        no_rx = 1'b1;
        run(3 * LEN);
        chk(rtd_timeout == 1'b1, "R4", "timeout raised", int'(rtd_timeout), 1);
        chk(int'(rtd_value) == held_val, "R4", "value kept", int'(rtd_value), held_val);
        no_rx = 1'b0;
        run(3 * LEN);
        chk(rtd_timeout == 1'b0, "R4", "timeout cleared", int'(rtd_timeout), 0);
        chk(int'(rtd_value) == 5 + held_depth, "R4", "value after recovery",
            int'(rtd_value), 5 + held_depth);

        // R9: disable calibration and ask for a far target.
        trial(6, 8);
        held_depth = int'(cal_depth);
        cal_en = 1'b0;
        cal_target = CW'(30);
        run(8 * LEN);
        chk(int'(cal_depth) == held_depth, "R9", "depth held", int'(cal_depth), held_depth);
        chk(cal_locked == 0 && cal_unreach == 0, "R9", "flags cleared",
            int'({cal_locked, cal_unreach}), 0);
        chk(int'(rtd_value) == 6 + held_depth, "R9", "measurement continues",
            int'(rtd_value), 6 + held_depth);
        cal_en = 1'b1;

        // Random cable delays and targets.
        for (int k = 0; k < 6; k++) begin
            int l;
            int t;
            l = 1 + int'($urandom % 20);
            t = l - 3 + int'($urandom % 12);
            if (t < 0) t = 0;
            trial(l, t);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule